// File: doc/BRIEF.md
# Accumulator ALU with Carry Flag

This block holds an accumulator register and a single carry/borrow flag, and changes them when an 8-bit opcode is executed. An outer sequencer fetches the memory operand, from the data-pointer address or from the byte after the opcode, and presents it on the operand port together with the opcode. The block supports logic operations, a direct load, add with or without carry, and two subtract directions: operand minus accumulator, and accumulator minus operand. Each subtract direction has a form with borrow. It also has logical and ring shifts in both directions.

The operation interface is a valid/ready pair. The block never applies back-pressure, so `op_ready` is held high. An operation is taken in every cycle in which `op_valid` is high, and the new accumulator and flag appear after that rising edge. A combinational `imm_operand` output tells the sequencer whether the opcode on the port takes its operand from the byte after the opcode. The sequencer uses this to advance the program pointer. Addressing, pointer updates and the register file belong to the sequencer.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released, `acc_d` reads 0x00 and `acc_df` reads 0.
- R2: `op_ready` is always 1. The state changes only on a rising edge where `op_valid` is 1, and the result is visible after that edge. When `op_valid` is 0, `acc_d` and `acc_df` keep their values.
- R3: Opcodes 0xF1/0xF9 set the accumulator to operand OR accumulator. Opcodes 0xF2/0xFA use AND, and opcodes 0xF3/0xFB use XOR. The flag is unchanged.
- R4: Opcode 0xF8 loads the operand into the accumulator and leaves the flag unchanged.
- R5: Opcodes 0xF4/0xFC add the operand to the accumulator and write the carry out to the flag. Opcodes 0x74/0x7C also add the old flag.
- R6: Opcodes 0xF5/0xFD compute operand minus accumulator. Opcodes 0x75/0x7D also subtract the inverse of the old flag. The flag is 1 when no borrow occurred and 0 when a borrow occurred.
- R7: Opcodes 0xF7/0xFF compute accumulator minus operand. Opcodes 0x77/0x7F also subtract the inverse of the old flag. The flag follows the same no-borrow rule as R6.
- R8: Opcode 0xF6 shifts the accumulator right, moves the old bit 0 into the flag and puts 0 into bit 7. Opcode 0x76 does the same but puts the old flag into bit 7.
- R9: Opcode 0xFE shifts the accumulator left, moves the old bit 7 into the flag and puts 0 into bit 0. Opcode 0x7E does the same but puts the old flag into bit 0.
- R10: `imm_operand` is 1 for opcodes 0xF8–0xFD, 0xFF, 0x7C, 0x7D and 0x7F. It is 0 for every other opcode, including 0xFE and 0x7E.
- R11: Any opcode not listed in R3–R9 leaves the accumulator and the flag unchanged, even when `op_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode and operand are presented for execution |
| op_ready | output | 1 | Always 1; the block accepts an operation in every cycle |
| opcode | input | 8 | Operation code |
| operand | input | 8 | Memory or immediate operand byte |
| imm_operand | output | 1 | Opcode takes its operand from the byte after the opcode |
| acc_d | output | 8 | Accumulator |
| acc_df | output | 1 | Carry / no-borrow / shift flag |

## Verification
`imm_operand` is combinational, so it is due in the same cycle as the opcode. The bench samples it on the falling edge after the opcode is driven. `acc_d` and `acc_df` are due one rising edge after the cycle in which `op_valid` is high. The bench raises `op_valid` on a falling edge, lowers it on the next falling edge, and compares both values at that second falling edge. The vector table runs as one chain, so each expected flag depends on the flag left by the vector before it.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OPW = 8;

  typedef enum logic [3:0] {
    K_NONE, K_LOAD, K_OR, K_AND, K_XOR,
    K_ADD, K_SUBD, K_SUBM, K_SHR, K_SHL
  } alu_kind_e;

  typedef struct packed {
    alu_kind_e kind;
    logic      chain;  // carry/borrow/ring bit comes from the old flag
    logic      imm;    // operand is the byte after the opcode
  } alu_dec_t;
endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output alu_dec_t       dec
);
  always_comb begin
    dec = '{kind: K_NONE, chain: 1'b0, imm: 1'b0};
    unique case (opcode)
      8'hF1: dec.kind = K_OR;
      8'hF2: dec.kind = K_AND;
      8'hF3: dec.kind = K_XOR;
      8'hF4: dec.kind = K_ADD;
      8'hF5: dec.kind = K_SUBD;
      8'hF6: dec.kind = K_SHR;
      8'hF7: dec.kind = K_SUBM;
      8'hF8: dec = '{kind: K_LOAD, chain: 1'b0, imm: 1'b1};
      8'hF9: dec = '{kind: K_OR,   chain: 1'b0, imm: 1'b1};
      8'hFA: dec = '{kind: K_AND,  chain: 1'b0, imm: 1'b1};
      8'hFB: dec = '{kind: K_XOR,  chain: 1'b0, imm: 1'b1};
      8'hFC: dec = '{kind: K_ADD,  chain: 1'b0, imm: 1'b1};
      8'hFD: dec = '{kind: K_SUBD, chain: 1'b0, imm: 1'b1};
      8'hFE: dec.kind = K_SHL;
      8'hFF: dec = '{kind: K_SUBM, chain: 1'b0, imm: 1'b1};
      8'h74: dec = '{kind: K_ADD,  chain: 1'b1, imm: 1'b0};
      8'h75: dec = '{kind: K_SUBD, chain: 1'b1, imm: 1'b0};
      8'h76: dec = '{kind: K_SHR,  chain: 1'b1, imm: 1'b0};
      8'h77: dec = '{kind: K_SUBM, chain: 1'b1, imm: 1'b0};
      8'h7C: dec = '{kind: K_ADD,  chain: 1'b1, imm: 1'b1};
      8'h7D: dec = '{kind: K_SUBD, chain: 1'b1, imm: 1'b1};
      8'h7E: dec = '{kind: K_SHL,  chain: 1'b1, imm: 1'b0};
      8'h7F: dec = '{kind: K_SUBM, chain: 1'b1, imm: 1'b1};
      default: ;
    endcase
  end

  // R10: a shift never asks the sequencer for an immediate byte
  always_comb begin
    assert_shift_not_imm_R10: assert (!(dec.imm && (dec.kind == K_SHL || dec.kind == K_SHR)));
  end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_dec_t      dec,
  input  logic [DW-1:0] d_in,
  input  logic          df_in,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] d_out,
  output logic          df_out,
  output logic          writes
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] add_a, add_b;
  logic          add_cin;
  logic [DW:0]   add_sum;

  // Shared adder: subtraction is a + ~b + cin, carry-out means no borrow
  always_comb begin
    add_a   = opnd;
    add_b   = d_in;
    add_cin = dec.chain ? df_in : 1'b0;
    unique case (dec.kind)
      K_SUBD: begin
        add_a   = opnd;
        add_b   = ~d_in;
        add_cin = dec.chain ? df_in : 1'b1;
      end
      K_SUBM: begin
        add_a   = d_in;
        add_b   = ~opnd;
        add_cin = dec.chain ? df_in : 1'b1;
      end
      default: ;
    endcase
    add_sum = {1'b0, add_a} + {1'b0, add_b} + {{DW{1'b0}}, add_cin};
  end

  always_comb begin
    d_out  = d_in;
    df_out = df_in;
    writes = 1'b1;
    unique case (dec.kind)
      K_LOAD: d_out = opnd;
      K_OR:   d_out = opnd | d_in;
      K_AND:  d_out = opnd & d_in;
      K_XOR:  d_out = opnd ^ d_in;
      K_ADD, K_SUBD, K_SUBM: begin
        d_out  = add_sum[DW-1:0];
        df_out = add_sum[DW];
      end
      K_SHR: begin
        d_out  = {dec.chain ? df_in : 1'b0, d_in[MSB:1]};
        df_out = d_in[0];
      end
      K_SHL: begin
        d_out  = {d_in[MSB-1:0], dec.chain ? df_in : 1'b0};
        df_out = d_in[MSB];
      end
      default: writes = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  output logic           op_ready,
  input  logic [OPW-1:0] opcode,
  input  logic [DW-1:0]  operand,
  output logic           imm_operand,
  output logic [DW-1:0]  acc_d,
  output logic           acc_df
);
  alu_dec_t      dec;
  logic [DW-1:0] nxt_d;
  logic          nxt_df;
  logic          writes;
  logic          fire;

  acc_alu_decode u_dec (.opcode(opcode), .dec(dec));

  acc_alu_exec #(.DW(DW)) u_exec (
    .dec(dec), .d_in(acc_d), .df_in(acc_df), .opnd(operand),
    .d_out(nxt_d), .df_out(nxt_df), .writes(writes)
  );

  assign op_ready    = 1'b1;
  assign imm_operand = dec.imm;
  assign fire        = op_valid && op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_d  <= '0;
      acc_df <= 1'b0;
    end else if (fire && writes) begin
      acc_d  <= nxt_d;
      acc_df <= nxt_df;
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_d) && $stable(acc_df)));

  assert_logic_keeps_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (dec.kind == K_OR || dec.kind == K_AND || dec.kind == K_XOR)) |=> $stable(acc_df));

  assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec.kind == K_LOAD) |=> (acc_d == $past(operand) && $stable(acc_df)));

  assert_sd_noborrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec.kind == K_SUBD && !dec.chain) |=> (acc_df == ($past(operand) >= $past(acc_d))));

  assert_sm_noborrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec.kind == K_SUBM && !dec.chain) |=> (acc_df == ($past(acc_d) >= $past(operand))));

  assert_shr_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec.kind == K_SHR) |=> (acc_df == $past(acc_d[0])));

  assert_shl_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec.kind == K_SHL) |=> (acc_df == $past(acc_d[DW-1])));

  assert_unhandled_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec.kind == K_NONE) |=> ($stable(acc_d) && $stable(acc_df)));
endmodule

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [7:0] opcode = 8'h00;
  logic [7:0] operand = 8'h00;
  logic       imm_operand;
  logic [7:0] acc_d;
  logic       acc_df;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .opcode(opcode), .operand(operand), .imm_operand(imm_operand),
    .acc_d(acc_d), .acc_df(acc_df)
  );

  // {opcode, operand, expected accumulator, expected flag}, run as one chain
  localparam int NV = 26;
  localparam logic [24:0] VEC [NV] = '{
    {8'hF8, 8'h5A, 8'h5A, 1'b0},  // R4 load
    {8'hF9, 8'h0F, 8'h5F, 1'b0},  // R3 OR imm
    {8'hFA, 8'h3C, 8'h1C, 1'b0},  // R3 AND imm
    {8'hFB, 8'hFF, 8'hE3, 1'b0},  // R3 XOR imm
    {8'hFC, 8'h20, 8'h03, 1'b1},  // R5 add with carry out
    {8'hF3, 8'h03, 8'h00, 1'b1},  // R3 XOR keeps flag
    {8'h7C, 8'h05, 8'h06, 1'b0},  // R5 add plus flag
    {8'hFF, 8'h07, 8'hFF, 1'b0},  // R7 borrow
    {8'h7F, 8'h01, 8'hFD, 1'b1},  // R7 with borrow in
    {8'hFD, 8'h00, 8'h03, 1'b0},  // R6 borrow
    {8'h7D, 8'h10, 8'h0C, 1'b1},  // R6 with borrow in
    {8'hF6, 8'h00, 8'h06, 1'b0},  // R8 logical right
    {8'hF8, 8'h81, 8'h81, 1'b0},  // R4 load
    {8'h76, 8'h00, 8'h40, 1'b1},  // R8 ring right, flag 0 in
    {8'h76, 8'h00, 8'hA0, 1'b0},  // R8 ring right, flag 1 in
    {8'hFE, 8'h00, 8'h40, 1'b1},  // R9 logical left
    {8'h7E, 8'h00, 8'h81, 1'b0},  // R9 ring left, flag 1 in
    {8'h7E, 8'h00, 8'h02, 1'b1},  // R9 ring left, flag 0 in
    {8'hF4, 8'hFE, 8'h00, 1'b1},  // R5 add wraps to zero
    {8'h74, 8'hFF, 8'h00, 1'b1},  // R5 carry in causes wrap
    {8'hF7, 8'h00, 8'h00, 1'b1},  // R7 equal, no borrow
    {8'hF5, 8'h01, 8'h01, 1'b1},  // R6 operand minus acc
    {8'h75, 8'h00, 8'hFF, 1'b0},  // R6 borrow
    {8'h77, 8'h01, 8'hFD, 1'b1},  // R7 borrow in
    {8'hF1, 8'h02, 8'hFF, 1'b1},  // R3 OR
    {8'hF2, 8'h0F, 8'h0F, 1'b1}   // R3 AND
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual {d,df}=%h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [7:0] opnd, input logic vld);
    @(negedge clk);
    opcode = op; operand = opnd; op_valid = vld;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic check_imm(input logic [7:0] op, input logic exp);
    @(negedge clk);
    opcode = op;
    #1;
    check("R10", {8'h00, imm_operand}, {8'h00, exp});
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {acc_d, acc_df}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {acc_d, acc_df}, 9'h000);
    check("R2", {8'h00, op_ready}, 9'h001);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][24:17], VEC[i][16:9], 1'b1);
      check($sformatf("vec%0d", i), {acc_d, acc_df}, VEC[i][8:0]);
    end

    // R11: unhandled opcodes with valid high leave state; state is 0F/1
    apply(8'h30, 8'hAA, 1'b1);
    check("R11", {acc_d, acc_df}, {8'h0F, 1'b1});
    apply(8'hF0, 8'hAA, 1'b1);
    check("R11", {acc_d, acc_df}, {8'h0F, 1'b1});
    apply(8'h7B, 8'hAA, 1'b1);
    check("R11", {acc_d, acc_df}, {8'h0F, 1'b1});

    // R2: a handled opcode without op_valid has no effect
    apply(8'hF8, 8'h77, 1'b0);
    check("R2", {acc_d, acc_df}, {8'h0F, 1'b1});
    apply(8'hFE, 8'h00, 1'b0);
    check("R2", {acc_d, acc_df}, {8'h0F, 1'b1});

    // R10: immediate flag
    check_imm(8'hF8, 1'b1);
    check_imm(8'hFD, 1'b1);
    check_imm(8'hFF, 1'b1);
    check_imm(8'hFE, 1'b0);
    check_imm(8'h7C, 1'b1);
    check_imm(8'h7F, 1'b1);
    check_imm(8'h7E, 1'b0);
    check_imm(8'hF1, 1'b0);
    check_imm(8'h30, 1'b0);

    // R1: reset in mid-run clears both registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {acc_d, acc_df}, 9'h000);
    rst_n = 1'b1;
    apply(8'hF6, 8'h00, 1'b1);
    check("R8", {acc_d, acc_df}, 9'h000);

    finish_run();
  end
endmodule